// File: doc/BRIEF.md
# TLB-Backed Address Translation Unit

This block turns 16-bit virtual addresses into 16-bit physical addresses for a paged memory with 1 KB pages. Each request is looked up first in a small fully associative translation buffer. On a miss the block reads one entry from an external single-level page-table RAM, indexed by the virtual page number. If that entry is valid, the block loads it into the buffer and completes the request. If it is invalid, the block reports a page fault.

Every buffer entry keeps a reference bit and a dirty bit for its page. An access sets the reference bit, and a write also sets the dirty bit. A free-running interval counter clears all reference bits together, so the reference bits act as a cheap stand-in for least-recently-used tracking when a victim has to be chosen. When a fill displaces a valid entry, the displaced page's number and status bits are reported on a separate output so that the surrounding system can update its page table.

The block accepts one request at a time. A hit responds in one cycle. A miss responds in two cycles, because of the extra page-table read.

Top module: `addr_xlate_unit`

## Requirements
- R1: The virtual page number is `req_vaddr[15:10]`. A translated address is `{frame[5:0], req_vaddr[9:0]}`, so the low 10 bits pass through unchanged (virtual 0x041C with page 1 in frame 7 gives 0x1C1C).
- R2: A request that hits the buffer is answered with `resp_valid` high one cycle after it is accepted, and it causes no page-table read.
- R3: A request that misses drives `pt_rd_en` high with `pt_rd_idx` equal to its page number in the cycle it is accepted. `ready` is then low for exactly one cycle, and the response appears two cycles after acceptance. A request presented while `ready` is low is ignored.
- R4: A page-table word has its valid flag in bit 6 and its frame number in bits 5:0. An invalid word yields `resp_fault`=1 with `resp_paddr`=0 and loads nothing, so a repeated access to that page misses again.
- R5: A fill goes into the lowest-numbered invalid entry. If every entry is valid, it goes into the lowest-numbered entry whose reference bit is clear. If every reference bit is set, it goes into entry 0.
- R6: Each hit or fill sets that entry's reference bit. All reference bits are cleared at the clock edge that ends every REF_INTERVAL cycles counted from reset. An access at that same edge still leaves its own bit set.
- R7: A write hit sets the entry's dirty bit. A fill caused by a write loads the entry with the dirty bit set, and a fill caused by a read loads it with the dirty bit clear.
- R8: When a fill replaces a valid entry, `upd_valid` pulses together with the fill's response. `upd_vpn`, `upd_ref` and `upd_dirty` carry the displaced entry's page number and its status bits as they stood before that edge.
- R9: After reset every buffer entry is invalid, `ready` is 1, and `resp_valid`, `resp_fault` and `upd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a store |
| req_vaddr | input | 16 | Virtual address |
| ready | output | 1 | Block can accept a request this cycle |
| pt_rd_en | output | 1 | Page-table read strobe |
| pt_rd_idx | output | 6 | Page-table index (virtual page number) |
| pt_rd_data | input | 7 | Page-table word, one cycle after the strobe |
| resp_valid | output | 1 | Response present |
| resp_fault | output | 1 | Page fault on this response |
| resp_paddr | output | 16 | Physical address (0 on fault) |
| upd_valid | output | 1 | A valid entry was displaced |
| upd_vpn | output | 6 | Page number of the displaced entry |
| upd_ref | output | 1 | Reference bit of the displaced entry |
| upd_dirty | output | 1 | Dirty bit of the displaced entry |

## Verification
Most wrong internal state in this block first becomes visible through the pattern of page-table reads. A corrupted tag or valid bit turns an expected hit into a `pt_rd_en` pulse in the same cycle, or makes an expected miss answer one cycle early. A wrong reference bit or a wrong victim choice stays hidden until a later fill displaces the wrong page. That shows up on `upd_vpn` two cycles after the fill's request, and then as a surplus or missing page-table read on the next access to either page. Dirty-bit errors appear only when their entry is displaced. For that reason the stimulus forces many evictions, at several phases of the reference-clear interval.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int VA_W  = 16;
    localparam int OFF_W = 10;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = 6;
    localparam int PA_W  = PFN_W + OFF_W;
    localparam int PTE_W = PFN_W + 1;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;
    typedef logic [OFF_W-1:0] off_t;

    typedef struct packed {
        logic valid;
        pfn_t pfn;
    } pte_t;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        pfn_t pfn;
        logic refd;
        logic dirty;
    } tlb_ent_t;

    typedef enum logic {ST_IDLE, ST_WALK} walk_st_t;

    function automatic logic [PA_W-1:0] make_pa(pfn_t f, off_t o);
        return {f, o};
    endfunction
endpackage

// File: rtl/xlt_ref_tick.sv
module xlt_ref_tick #(
    parameter int INTERVAL = 1024
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == CNT_W'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R6
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
endmodule

// File: rtl/xlt_tlb_array.sv
module xlt_tlb_array
    import xlt_pkg::*;
#(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  vpn_t             lk_vpn,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output pfn_t             hit_pfn,
    output logic [IDX_W-1:0] victim_idx,
    output tlb_ent_t         victim_ent,
    input  logic             ref_clr,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  tlb_ent_t         fill_ent
);
    tlb_ent_t         ent [N];
    logic [N-1:0]     hit_vec;

    for (genvar i = 0; i < N; i++) begin : g_ent
        assign hit_vec[i] = ent[i].valid && (ent[i].vpn == lk_vpn);

        always_ff @(posedge clk) begin
            if (rst) begin
                ent[i] <= '0;
            end else begin
                if (ref_clr) ent[i].refd <= 1'b0;
                if (acc_en && acc_idx == IDX_W'(i)) begin
                    ent[i].refd <= 1'b1;
                    if (acc_wr) ent[i].dirty <= 1'b1;
                end
                if (fill_en && fill_idx == IDX_W'(i)) ent[i] <= fill_ent;
            end
        end
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
    assign hit     = |hit_vec;
    assign hit_pfn = ent[hit_idx].pfn;

    always_comb begin
        logic             inv_found, old_found;
        logic [IDX_W-1:0] inv_idx, old_idx;
        inv_found = 1'b0;
        old_found = 1'b0;
        inv_idx   = '0;
        old_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent[i].valid) begin
                inv_found = 1'b1;
                inv_idx   = IDX_W'(i);
            end
            if (!ent[i].refd) begin
                old_found = 1'b1;
                old_idx   = IDX_W'(i);
            end
        end
        if (inv_found)      victim_idx = inv_idx;
        else if (old_found) victim_idx = old_idx;
        else                victim_idx = '0;
    end
    assign victim_ent = ent[victim_idx];

    // R5
    single_hit_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec));
    // R5
    fill_miss_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> !(victim_ent.valid && !victim_ent.refd && $countones(hit_vec) != 0 && hit_vec[victim_idx]));
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
    import xlt_pkg::*;
#(
    parameter int TLB_N        = 4,
    parameter int REF_INTERVAL = 1024,
    localparam int IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             ready,
    output logic             pt_rd_en,
    output logic [VPN_W-1:0] pt_rd_idx,
    input  logic [PTE_W-1:0] pt_rd_data,
    output logic             resp_valid,
    output logic             resp_fault,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             upd_valid,
    output logic [VPN_W-1:0] upd_vpn,
    output logic             upd_ref,
    output logic             upd_dirty
);
    walk_st_t         state;
    vpn_t             pend_vpn;
    off_t             pend_off;
    logic             pend_wr;
    vpn_t             req_vpn;
    off_t             req_off;
    logic             accept, walking, hit, ref_clr, fill_en, acc_en;
    logic [IDX_W-1:0] hit_idx, victim_idx;
    pfn_t             hit_pfn;
    tlb_ent_t         victim_ent, fill_ent;
    pte_t             pte;

    assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign req_off   = req_vaddr[OFF_W-1:0];
    assign ready     = (state == ST_IDLE);
    assign accept    = req_valid && ready && !rst;
    assign walking   = (state == ST_WALK);
    assign pte       = pte_t'(pt_rd_data);
    assign acc_en    = accept && hit;
    assign pt_rd_en  = accept && !hit;
    assign pt_rd_idx = req_vpn;
    assign fill_en   = walking && pte.valid;

    always_comb begin
        fill_ent       = '0;
        fill_ent.valid = 1'b1;
        fill_ent.vpn   = pend_vpn;
        fill_ent.pfn   = pte.pfn;
        fill_ent.refd  = 1'b1;
        fill_ent.dirty = pend_wr;
    end

    xlt_ref_tick #(.INTERVAL(REF_INTERVAL)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(ref_clr)
    );

    xlt_tlb_array #(.N(TLB_N)) u_tlb (
        .clk       (clk),
        .rst       (rst),
        .lk_vpn    (req_vpn),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_pfn   (hit_pfn),
        .victim_idx(victim_idx),
        .victim_ent(victim_ent),
        .ref_clr   (ref_clr),
        .acc_en    (acc_en),
        .acc_wr    (req_write),
        .acc_idx   (hit_idx),
        .fill_en   (fill_en),
        .fill_idx  (victim_idx),
        .fill_ent  (fill_ent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pend_vpn <= '0;
            pend_off <= '0;
            pend_wr  <= 1'b0;
        end else if (pt_rd_en) begin
            state    <= ST_WALK;
            pend_vpn <= req_vpn;
            pend_off <= req_off;
            pend_wr  <= req_write;
        end else if (walking) begin
            state <= ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_fault <= 1'b0;
            resp_paddr <= '0;
            upd_valid  <= 1'b0;
            upd_vpn    <= '0;
            upd_ref    <= 1'b0;
            upd_dirty  <= 1'b0;
        end else begin
            resp_valid <= acc_en || walking;
            resp_fault <= walking && !pte.valid;
            if (acc_en)       resp_paddr <= make_pa(hit_pfn, req_off);
            else if (fill_en) resp_paddr <= make_pa(pte.pfn, pend_off);
            else              resp_paddr <= '0;
            upd_valid <= fill_en && victim_ent.valid;
            upd_vpn   <= victim_ent.vpn;
            upd_ref   <= victim_ent.refd;
            upd_dirty <= victim_ent.dirty;
        end
    end

    // R3
    walk_busy_chk: assert property (@(posedge clk) disable iff (rst) pt_rd_en |=> !ready);
    // R3
    walk_resp_chk: assert property (@(posedge clk) disable iff (rst) $past(pt_rd_en) |=> resp_valid);
    // R2
    hit_resp_chk: assert property (@(posedge clk) disable iff (rst) (accept && !pt_rd_en) |=> (resp_valid && !resp_fault));
    // R4
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst) resp_fault |-> (resp_valid && resp_paddr == '0));
    // R8
    evict_fill_chk: assert property (@(posedge clk) disable iff (rst) upd_valid |-> (resp_valid && !resp_fault));
endmodule

// File: tb/sim_addr_xlate_unit.sv
module sim_addr_xlate_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int RI = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        ready, pt_rd_en, resp_valid, resp_fault;
    logic [5:0]  pt_rd_idx, upd_vpn;
    logic [6:0]  pt_rd_data = '0;
    logic [15:0] resp_paddr;
    logic        upd_valid, upd_ref, upd_dirty;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_xlate_unit #(.TLB_N(N), .REF_INTERVAL(RI)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_vaddr(req_vaddr), .ready(ready), .pt_rd_en(pt_rd_en),
        .pt_rd_idx(pt_rd_idx), .pt_rd_data(pt_rd_data), .resp_valid(resp_valid),
        .resp_fault(resp_fault), .resp_paddr(resp_paddr), .upd_valid(upd_valid),
        .upd_vpn(upd_vpn), .upd_ref(upd_ref), .upd_dirty(upd_dirty));

    // page-table RAM: bit 6 valid, bits 5:0 frame (R4)
    bit pt_v [64];
    int pt_f [64];
    always @(posedge clk)
        if (pt_rd_en) pt_rd_data <= {pt_v[pt_rd_idx], 6'(pt_f[pt_rd_idx])};

    // behavioural reference model
    int m_v[N], m_vpn[N], m_pfn[N], m_ref[N], m_dirty[N];
    int m_cnt, m_pvpn, m_poff, m_pwr;
    bit m_walk;
    int e_rv, e_rf, e_pa, e_uv, e_uvpn, e_uref, e_ud;

    function automatic int m_find(int vpn);
        for (int i = 0; i < N; i++) if (m_v[i] != 0 && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic int m_pick();
        for (int i = 0; i < N; i++) if (m_v[i] == 0) return i;
        for (int i = 0; i < N; i++) if (m_ref[i] == 0) return i;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_v[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_ref[i] = 0; m_dirty[i] = 0;
            end
            m_cnt = 0; m_walk = 0; m_pvpn = 0; m_poff = 0; m_pwr = 0;
            e_rv = 0; e_rf = 0; e_pa = 0; e_uv = 0; e_uvpn = 0; e_uref = 0; e_ud = 0;
        end else begin
            bit clr;
            int vic, vref, h, vpn, off;
            clr = (m_cnt == RI - 1);
            m_cnt = clr ? 0 : m_cnt + 1;
            vic = m_pick();
            vref = m_ref[vic];
            e_rv = 0; e_rf = 0; e_pa = 0; e_uv = 0;
            if (clr) for (int i = 0; i < N; i++) m_ref[i] = 0;
            vpn = int'(req_vaddr[15:10]);
            off = int'(req_vaddr[9:0]);
            if (m_walk) begin
                m_walk = 0;
                e_rv = 1;
                if (!pt_v[m_pvpn]) begin
                    e_rf = 1;
                end else begin
                    if (m_v[vic] != 0) begin
                        e_uv = 1; e_uvpn = m_vpn[vic]; e_uref = vref; e_ud = m_dirty[vic];
                    end
                    m_v[vic] = 1; m_vpn[vic] = m_pvpn; m_pfn[vic] = pt_f[m_pvpn];
                    m_ref[vic] = 1; m_dirty[vic] = m_pwr;
                    e_pa = pt_f[m_pvpn] * 1024 + m_poff;
                end
            end else if (req_valid) begin
                h = m_find(vpn);
                if (h >= 0) begin
                    e_rv = 1;
                    e_pa = m_pfn[h] * 1024 + off;
                    m_ref[h] = 1;
                    if (req_write) m_dirty[h] = 1;
                end else begin
                    m_walk = 1; m_pvpn = vpn; m_poff = off; m_pwr = int'(req_write);
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle compare, away from the edges
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            bit exp_rd;
            exp_rd = req_valid && !m_walk && (m_find(int'(req_vaddr[15:10])) < 0);
            chk("R3 ready", int'(ready), int'(!m_walk));
            chk("R2 R3 R5 pt_rd_en", int'(pt_rd_en), int'(exp_rd));
            if (exp_rd) chk("R3 pt_rd_idx", int'(pt_rd_idx), int'(req_vaddr[15:10]));
            chk("R2 R3 resp_valid", int'(resp_valid), e_rv);
            chk("R4 resp_fault", int'(resp_fault), e_rf);
            if (e_rv != 0) chk("R1 R4 resp_paddr", int'(resp_paddr), e_pa);
            chk("R5 R8 upd_valid", int'(upd_valid), e_uv);
            if (e_uv != 0) begin
                chk("R5 R8 upd_vpn", int'(upd_vpn), e_uvpn);
                chk("R6 R8 upd_ref", int'(upd_ref), e_uref);
                chk("R7 R8 upd_dirty", int'(upd_dirty), e_ud);
            end
        end
    end

    task automatic access(input logic [15:0] a, input bit wr, input int gap);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = a; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            pt_v[i] = (i >= 8 && i < 40); pt_f[i] = (i ^ 42) & 63;
        end
        pt_v[1] = 1; pt_f[1] = 7;
        pt_v[5] = 1; pt_f[5] = 0;
        pt_v[2] = 0;
        pt_v[20] = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        chk("R9 ready after reset", int'(ready), 1);
        chk("R9 resp_valid after reset", int'(resp_valid), 0);
        chk("R9 upd_valid after reset", int'(upd_valid), 0);

        access(16'h041C, 0, 2);        // R1: miss, 0x1C1C
        access(16'h0420, 1, 1);        // R2 R7: write hit
        access(16'h08AD, 0, 2);        // R4: fault
        access(16'h08AD, 0, 2);        // R4: no fill, faults again
        access(16'h157B, 0, 2);        // R1: 0x017B
        access(16'h2000, 1, 2);        // R7: write fill
        access(16'h2404, 0, 2);
        access(16'h2808, 0, 2);        // R5 R8: full, evict
        // R3: request held into the walk cycle is ignored
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 16'h2C11; req_write = 1'b0;
        @(negedge clk);
        req_vaddr = 16'h3022;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        repeat (45) @(negedge clk);    // R6: let a clear pass
        access(16'h2C00, 1, 1);
        access(16'h3400, 0, 2);        // R5: victim with clear ref
        for (int i = 0; i < 60; i++) begin
            logic [5:0] v;
            v = 6'(8 + ((i * 7) % 13));
            if (i % 9 == 4) v = 6'd20;
            access({v, 10'(i * 37)}, (i % 3) == 0, i % 4);
        end
        // R6: clear coinciding with accesses at various phases
        for (int i = 0; i < 40; i++) access({6'(8 + (i % 6)), 10'(i)}, (i % 2) == 1, 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule